// File: doc/BRIEF.md
# Dual-Bank USB IN Endpoint Buffer

This block holds the outgoing data of one USB IN endpoint in one or more byte banks, two by default. A CPU fills the bank it currently points at one byte per cycle. It then hands the bank to the USB side through a short flag handshake. The USB side answers each host IN token in one of two ways. It replies NAK when nothing is committed. Otherwise it streams the oldest committed bank out byte by byte and waits for the host ACK, which returns the bank to the CPU.

The CPU sees three status flags: a bank-free flag, an ownership flag and a write-room flag. It also sees a sticky protocol-error flag and a maskable interrupt. Software first clears the bank-free flag and writes its data. It then clears the ownership flag to commit the bank. The commit advances the CPU to the next bank, and the flags then show that bank's state. Packet encoding, CRC, data toggles and the PHY sit outside this block.

Top module: `usb_in_ep_buf`

## Requirements
- R1: After reset the bank-free flag (`txini`), the ownership flag (`fifocon`) and `rwal` are 1. `proto_err`, `ep_irq`, `nak`, `tx_valid` and `tx_eop` are 0.
- R2: `ep_irq` is high exactly when `txini` is 1 and `irq_en` is 1.
- R3: A flag write (`flag_wr_en`) clears bit 0 = `txini`, bit 1 = `fifocon` and bit 2 = `proto_err` when the corresponding data bit is 0. A 1 in any position leaves that flag unchanged.
- R4: Clearing `fifocon` while `txini` is 0 commits the current bank and moves the CPU to the next bank in round-robin order. From the next cycle, `txini` and `fifocon` are both 1 if that bank is free, and both 0 if it is still committed.
- R5: Clearing `fifocon` while `txini` is 1 is ignored: `fifocon` stays 1, no bank is committed, and `proto_err` becomes 1. `proto_err` stays 1 until it is cleared through bit 2.
- R6: `rwal` is 1 exactly when the CPU owns its current bank and that bank holds fewer than BANK_BYTES bytes. A byte written while `rwal` is 0 is dropped.
- R7: An IN token with no committed bank gives a one-cycle `nak` pulse in the next cycle and no data.
- R8: An IN token with a committed bank starts sending in the next cycle. The bytes come out on consecutive cycles in the order written, one per cycle, and `tx_eop` is high with the last byte. A bank committed with zero bytes gives one cycle of `tx_eop` with `tx_valid` low.
- R9: An `ack` after a packet frees that bank. If the freed bank is the CPU's current bank, `txini` and `fifocon` rise in the next cycle. An `ack` at any other time is ignored.
- R10: Committed banks are sent in the order they were committed.
- R11: An IN token that arrives while the block waits for `ack` sends the same bank again from its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU byte write strobe |
| cpu_wr_data | input | 8 | CPU byte |
| flag_wr_en | input | 1 | Flag write strobe |
| flag_wr_data | input | 3 | Flag write value; a 0 bit clears that flag |
| irq_en | input | 1 | Interrupt enable |
| txini | output | 1 | Current bank has become free |
| fifocon | output | 1 | CPU owns current bank |
| rwal | output | 1 | CPU may write a byte |
| proto_err | output | 1 | Sticky out-of-order clear error |
| ep_irq | output | 1 | Endpoint interrupt |
| in_token | input | 1 | Host IN token strobe |
| ack | input | 1 | Host ACK strobe |
| nak | output | 1 | NAK reply pulse |
| tx_valid | output | 1 | Byte valid on tx_data |
| tx_data | output | 8 | Outgoing byte |
| tx_eop | output | 1 | End of packet |

## Verification
Flag writes, commits and ACKs show their results on `txini`, `fifocon`, `rwal` and `proto_err` one cycle after the edge that samples them. `rwal` and `ep_irq` follow combinationally from that state. `nak` and the first byte appear one cycle after the IN token. Each later byte follows one cycle after the one before it. The bench drives every input on a falling edge and holds it for one rising edge. It reads outputs on the following falling edge, so each check lands in the cycle where its result is due.

// File: rtl/usb_in_ep_buf.sv
module usb_in_ep_buf #(
  parameter int BANK_BYTES = 64,
  parameter int NUM_BANKS  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_wr_en,
  input  logic [7:0] cpu_wr_data,
  input  logic       flag_wr_en,
  input  logic [2:0] flag_wr_data,
  input  logic       irq_en,
  output logic       txini,
  output logic       fifocon,
  output logic       rwal,
  output logic       proto_err,
  output logic       ep_irq,
  input  logic       in_token,
  input  logic       ack,
  output logic       nak,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_eop
);

  localparam int CW = $clog2(BANK_BYTES + 1);
  localparam int IW = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1;
  localparam int PW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} st_t;

  logic [7:0]           mem [NUM_BANKS][BANK_BYTES];
  logic [CW-1:0]        cnt [NUM_BANKS];
  logic [NUM_BANKS-1:0] full_q, full_n;
  logic [PW-1:0]        cpu_ptr, cpu_ptr_n, usb_ptr;
  logic                 txini_q, fifocon_q, err_q, nak_q;
  st_t                  st;
  logic [CW-1:0]        rd_idx, tx_cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(NUM_BANKS - 1)) ? '0 : p + PW'(1);
  endfunction

  wire clr_fc  = flag_wr_en && !flag_wr_data[1];
  wire commit  = clr_fc && fifocon_q && !txini_q;
  wire bad_clr = clr_fc && fifocon_q && txini_q;
  wire freed   = (st == S_WAIT) && ack;
  wire wr_ok   = cpu_wr_en && rwal;

  assign rwal      = fifocon_q && (cnt[cpu_ptr] < CW'(BANK_BYTES));
  assign txini     = txini_q;
  assign fifocon   = fifocon_q;
  assign proto_err = err_q;
  assign ep_irq    = txini_q && irq_en;
  assign nak       = nak_q;
  assign tx_cnt    = cnt[usb_ptr];
  assign tx_valid  = (st == S_SEND) && (tx_cnt != '0);
  assign tx_eop    = (st == S_SEND) && ((tx_cnt == '0) || (rd_idx == tx_cnt - CW'(1)));
  assign tx_data   = mem[usb_ptr][rd_idx[IW-1:0]];

  always_comb begin
    full_n = full_q;
    if (commit) full_n[cpu_ptr] = 1'b1;
    if (freed)  full_n[usb_ptr] = 1'b0;
    cpu_ptr_n = commit ? nxt(cpu_ptr) : cpu_ptr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txini_q   <= 1'b1;
      fifocon_q <= 1'b1;
      err_q     <= 1'b0;
      cpu_ptr   <= '0;
      full_q    <= '0;
    end else begin
      full_q  <= full_n;
      cpu_ptr <= cpu_ptr_n;
      if (commit) begin
        txini_q   <= !full_n[cpu_ptr_n];
        fifocon_q <= !full_n[cpu_ptr_n];
      end else if (freed && usb_ptr == cpu_ptr && !fifocon_q) begin
        txini_q   <= 1'b1;
        fifocon_q <= 1'b1;
      end else if (flag_wr_en && !flag_wr_data[0]) begin
        txini_q <= 1'b0;
      end
      if (bad_clr) err_q <= 1'b1;
      else if (flag_wr_en && !flag_wr_data[2]) err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[cpu_ptr][cnt[cpu_ptr][IW-1:0]] <= cpu_wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++) cnt[b] <= '0;
    end else begin
      if (wr_ok) cnt[cpu_ptr] <= cnt[cpu_ptr] + CW'(1);
      if (freed) cnt[usb_ptr] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      rd_idx  <= '0;
      usb_ptr <= '0;
      nak_q   <= 1'b0;
    end else begin
      nak_q <= 1'b0;
      case (st)
        S_IDLE: if (in_token) begin
          if (full_q[usb_ptr]) begin
            st     <= S_SEND;
            rd_idx <= '0;
          end else begin
            nak_q <= 1'b1;
          end
        end
        S_SEND: begin
          if (tx_eop) st <= S_WAIT;
          else rd_idx <= rd_idx + CW'(1);
        end
        S_WAIT: begin
          if (ack) begin
            st      <= S_IDLE;
            usb_ptr <= nxt(usb_ptr);
          end else if (in_token) begin
            st     <= S_SEND;
            rd_idx <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module usb_in_ep_buf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flag_wr_en,
  input logic [2:0] flag_wr_data,
  input logic       irq_en,
  input logic       txini,
  input logic       fifocon,
  input logic       rwal,
  input logic       proto_err,
  input logic       ep_irq,
  input logic       in_token,
  input logic       ack,
  input logic       nak,
  input logic       tx_valid,
  input logic       tx_eop
);

  p_irq_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !ep_irq);

  p_one_noop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_en && flag_wr_data[1:0] == 2'b11 && !txini && !ack) |=> !txini);

  p_bad_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_en && !flag_wr_data[1] && txini && fifocon) |=> (proto_err && fifocon));

  p_room_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rwal |-> fifocon);

  p_nak_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nak |-> ($past(in_token) && !tx_valid));

  p_eop_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_eop |=> !tx_valid);

endmodule

bind usb_in_ep_buf usb_in_ep_buf_chk i_chk (.*);

// File: tb/test_usb_in_ep_buf.sv
module test_usb_in_ep_buf;
  localparam int CLK_PERIOD = 10;
  localparam int BB = 8;

  logic clk = 0, rst_n = 0;
  logic cpu_wr_en = 0, flag_wr_en = 0, irq_en = 0, in_token = 0, ack = 0;
  logic [7:0] cpu_wr_data = 0;
  logic [2:0] flag_wr_data = 3'b111;
  logic txini, fifocon, rwal, proto_err, ep_irq, nak, tx_valid, tx_eop;
  logic [7:0] tx_data;
  int total = 0, bad = 0;
  logic [7:0] rx [32];
  int rx_n;
  logic rx_eop_only;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_in_ep_buf #(.BANK_BYTES(BB), .NUM_BANKS(2)) i_usb_in_ep_buf (.*);

  // op 0 = byte write, op 1 = flag write; expected {txini,fifocon,rwal,proto_err}
  localparam int NV = 12;
  localparam logic [13:0] TBL [NV] = '{
    {2'd1, 8'h06, 4'b0110},  // R3 clear txini
    {2'd0, 8'hAA, 4'b0110},  // R6
    {2'd0, 8'hBB, 4'b0110},  // R6
    {2'd1, 8'h05, 4'b1110},  // R4 commit bank0, bank1 free
    {2'd0, 8'h01, 4'b1110},  // R6
    {2'd1, 8'h05, 4'b1111},  // R5 out of order
    {2'd1, 8'h03, 4'b1110},  // R5 clear error via bit 2
    {2'd1, 8'h06, 4'b0110},  // R3
    {2'd0, 8'h02, 4'b0110},  // R6
    {2'd1, 8'h05, 4'b0000},  // R4 both banks committed
    {2'd0, 8'h03, 4'b0000},  // R6 dropped
    {2'd1, 8'h07, 4'b0000}   // R3 ones have no effect
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic op(input logic [1:0] kind, input logic [7:0] arg);
    if (kind == 2'd0) begin cpu_wr_en = 1; cpu_wr_data = arg; end
    else if (kind == 2'd1) begin flag_wr_en = 1; flag_wr_data = arg[2:0]; end
    else if (kind == 2'd2) in_token = 1;
    else ack = 1;
    cyc();
    cpu_wr_en = 0; flag_wr_en = 0; flag_wr_data = 3'b111; in_token = 0; ack = 0;
  endtask

  task automatic flags(input string tag, input logic [3:0] exp);
    chk(tag, {txini, fifocon, rwal, proto_err}, exp);
  endtask

  task automatic get_pkt;
    rx_n = 0;
    rx_eop_only = 0;
    for (int i = 0; i < 20; i++) begin
      if (tx_valid) begin rx[rx_n] = tx_data; rx_n++; end
      else if (tx_eop) rx_eop_only = 1;
      if (tx_eop || (!tx_valid && !tx_eop)) break;
      cyc();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); cyc();
    rst_n = 1;
    @(negedge clk);
    flags("R1 reset flags", 4'b1110);
    chk("R1 reset outputs", {ep_irq, nak, tx_valid, tx_eop}, 4'b0000);

    for (int v = 0; v < NV; v++) begin
      op(TBL[v][13:12], TBL[v][11:4]);
      flags($sformatf("R3/R4/R5/R6 row %0d", v), TBL[v][3:0]);
    end

    op(2'd2, 8'h00);  // IN -> bank0
    get_pkt();
    chk("R8 bank0 length", rx_n, 2);
    chk("R8 bank0 bytes", {rx[0], rx[1]}, 16'hAABB);
    cyc();
    chk("R8 idle after eop", tx_valid, 1'b0);
    op(2'd3, 8'h00);  // ACK bank0
    flags("R9 ack frees current bank", 4'b1110);

    op(2'd2, 8'h00);  // IN -> bank1
    get_pkt();
    chk("R10 bank1 order and R6 drop", {rx_n[7:0], rx[0], rx[1]}, 24'h020102);
    cyc();
    op(2'd2, 8'h00);  // retry while waiting
    get_pkt();
    chk("R11 resend same bank", {rx_n[7:0], rx[0], rx[1]}, 24'h020102);
    cyc();
    op(2'd3, 8'h00);
    flags("R9 ack of other bank", 4'b1110);
    op(2'd3, 8'h00);  // stray ack
    flags("R9 stray ack ignored", 4'b1110);
    op(2'd2, 8'h00);
    chk("R7 nak pulse", {nak, tx_valid}, 2'b10);
    cyc();
    chk("R7 nak one cycle", nak, 1'b0);

    irq_en = 1; #1;
    chk("R2 irq on", ep_irq, 1'b1);
    op(2'd1, 8'h06);
    chk("R2 irq off after clear", ep_irq, 1'b0);
    irq_en = 0;

    for (int i = 0; i < BB; i++) op(2'd0, 8'h10 + 8'(i));
    chk("R6 full bank no room", rwal, 1'b0);
    op(2'd0, 8'hEE);
    op(2'd1, 8'h05);  // commit full bank0
    flags("R4 switch to free bank1", 4'b1110);
    op(2'd1, 8'h06);
    op(2'd1, 8'h05);  // commit empty bank1
    flags("R4 both committed", 4'b0000);

    op(2'd2, 8'h00);
    get_pkt();
    chk("R8 full length", rx_n, BB);
    for (int i = 0; i < BB; i++)
      chk($sformatf("R8 byte %0d", i), rx[i], 8'h10 + 8'(i));
    cyc();
    op(2'd3, 8'h00);
    flags("R9 freed returns to cpu", 4'b1110);

    op(2'd2, 8'h00);
    get_pkt();
    chk("R8 empty packet", {rx_n[3:0], rx_eop_only}, 5'b00001);
    cyc();
    op(2'd3, 8'h00);
    op(2'd2, 8'h00);
    chk("R7 nak after all sent", nak, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule